// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block receives 12-bit command words on a serial line and holds the settings of a four-channel, 8-bit DAC. Each word is either a write of one channel's output code or a write of a packed control register. The control register holds a per-channel gain range bit, a per-channel shutdown-inhibit bit, a software activate bit and an interface mode bit. The mode bit is stored and shown on a pin, and it changes nothing else. The block drives four 8-bit codes, four range selects and four active/shutdown status lines. Each status line combines the channel's inhibit bit, the software activate bit and a hardware activate pin that passes through a two-flop synchronizer.

All logic runs on the rising edge of the serial clock. While the frame strobe is high, one bit is sampled on every edge, and the first bit sent is the most significant. A word is accepted on the first rising edge at which the strobe is seen low again. It takes effect only if exactly 12 bits arrived and the first of them was 1. Any other frame leaves every register unchanged. The serial input is a plain bit stream with no valid/ready handshake and no back-pressure: one bit is taken on every edge while the strobe is high, and the strobe alone frames the data.

Top module: `qdac_serial_regs`

## Requirements
- R1: After the asynchronous reset, all four codes are 0x00, all range outputs are 1, the mode output is 0 and all status outputs are 0 (shutdown).
- R2: A frame is accepted on the first rising edge with the strobe low that follows a run of high-strobe edges. Its effect is visible right after that edge. The first bit sent is word bit 11, which is the start bit.
- R3: A data write has bit 10 = 1. Bits 9:8 give the channel (00 = A, 01 = B, 10 = C, 11 = D) and bits 7:0 give the code. Only that channel's code changes, and the range, inhibit, activate and mode values are kept.
- R4: A control write has bit 10 = 0. The layout is bit 9 mode, bits 8..5 range A..D, bits 4..1 inhibit A..D and bit 0 activate. The write replaces all ten bits and leaves the codes unchanged. A range value of 0 selects x1 gain and 1 selects x2 gain.
- R5: A channel whose inhibit bit is 1 reports active (1), whatever the activate bit and the hardware pin are.
- R6: A channel whose inhibit bit is 0 reports active only when the activate bit and the synchronized hardware pin are both 1. Otherwise it reports shutdown (0).
- R7: A change on the hardware activate pin reaches the status outputs after the second rising clock edge, and not after the first.
- R8: A frame of 11 or of 13 bits is discarded, and codes and control bits keep their values.
- R9: A 12-bit frame whose start bit is 0 is discarded, and codes and control bits keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; every register samples on its rising edge |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| sdi | input | 1 | Serial data, most significant bit first |
| frame | input | 1 | Frame strobe, high while the bits of a word are being sent |
| hw_act | input | 1 | Hardware activate pin, asynchronous |
| code_o | output | 32 | Channel codes, channel n at bits 8n+7:8n (A = 0) |
| range_o | output | 4 | Range select per channel, bit 0 = A (0 = x1, 1 = x2) |
| mode_o | output | 1 | Stored interface mode bit |
| active_o | output | 4 | Channel status, bit 0 = A (1 = active, 0 = shutdown) |

## Verification
The hardest cases to reach from the ports are frames that are almost valid: one bit short, one bit long, or the right length but with a 0 start bit. Each of these must leave every register unchanged. The bench drives them with a single task that sends an arbitrary bit count from an arbitrary pattern. It then reads all codes, ranges and the mode pin against a model kept in the bench. The synchronizer latency is checked by changing the hardware pin at a falling edge and sampling the status after one rising edge and again after two.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef enum logic {
    CMD_CTRL = 1'b0,
    CMD_DATA = 1'b1
  } cmd_kind_e;
endpackage

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdi,
  input  logic               frame,
  output logic [FRAME_W-1:0] word_o,
  output logic               commit_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   cnt;
  logic               frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      cnt     <= '0;
      frame_q <= 1'b0;
    end else begin
      frame_q <= frame;
      if (frame) begin
        sreg <= {sreg[FRAME_W-2:0], sdi};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
    end
  end

  assign word_o   = sreg;
  assign commit_o = frame_q && !frame && (cnt == CNT_FULL) && sreg[FRAME_W-1];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX); // R8
  AST_COMMIT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (cnt == '0)); // R2
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CODE_W  = 8,
  parameter int FRAME_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_i,
  input  logic [FRAME_W-2:0]       word_i,
  output logic [NUM_CH*CODE_W-1:0] codes_o,
  output logic [NUM_CH-1:0]        range_o,
  output logic [NUM_CH-1:0]        inhibit_o,
  output logic                     act_o,
  output logic                     mode_o
);
  localparam int ADDR_W   = $clog2(NUM_CH);
  localparam int KIND_BIT = FRAME_W - 2;
  localparam int MODE_BIT = FRAME_W - 3;
  localparam int RNG_TOP  = FRAME_W - 4;
  localparam int SI_TOP   = RNG_TOP - NUM_CH;
  localparam int ACT_BIT  = SI_TOP - NUM_CH;

  cmd_kind_e         kind;
  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] code_in;
  logic              wr_data;
  logic              wr_ctrl;

  assign kind    = cmd_kind_e'(word_i[KIND_BIT]);
  assign addr    = word_i[MODE_BIT -: ADDR_W];
  assign code_in = word_i[CODE_W-1:0];
  assign wr_data = commit_i && (kind == CMD_DATA);
  assign wr_ctrl = commit_i && (kind == CMD_CTRL);

  logic [CODE_W-1:0] code_q [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[ch] <= '0;
      end else if (wr_data && (addr == ADDR_W'(ch))) begin
        code_q[ch] <= code_in;
      end
    end
    assign codes_o[ch*CODE_W +: CODE_W] = code_q[ch];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_o   <= '1;
      inhibit_o <= '0;
      act_o     <= 1'b0;
      mode_o    <= 1'b0;
    end else if (wr_ctrl) begin
      mode_o <= word_i[MODE_BIT];
      act_o  <= word_i[ACT_BIT];
      for (int i = 0; i < NUM_CH; i++) begin
        range_o[i]   <= word_i[RNG_TOP - i];
        inhibit_o[i] <= word_i[SI_TOP - i];
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(codes_o) && $stable(range_o) && $stable(inhibit_o)
                  && $stable(act_o) && $stable(mode_o))); // R8
  AST_DATA_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> ($stable(range_o) && $stable(inhibit_o) && $stable(act_o)
                && $stable(mode_o))); // R3
  AST_CTRL_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> $stable(codes_o)); // R4
endmodule

// File: rtl/qdac_status.sv
module qdac_status #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_act,
  input  logic [NUM_CH-1:0] inhibit_i,
  input  logic              act_i,
  output logic [NUM_CH-1:0] active_o
);
  logic hw_meta;
  logic hw_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_meta <= 1'b0;
      hw_sync <= 1'b0;
    end else begin
      hw_meta <= hw_act;
      hw_sync <= hw_meta;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_stat
    assign active_o[ch] = inhibit_i[ch] | (act_i & hw_sync);
  end

  AST_INHIBIT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((active_o | inhibit_i) == active_o)); // R5
  AST_GATED_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (|(active_o & ~inhibit_i)) |-> (act_i && hw_sync)); // R6
endmodule

// File: rtl/qdac_serial_regs.sv
module qdac_serial_regs #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8
) (
  input  logic                     sclk,
  input  logic                     rst_n,
  input  logic                     sdi,
  input  logic                     frame,
  input  logic                     hw_act,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        range_o,
  output logic                     mode_o,
  output logic [NUM_CH-1:0]        active_o
);
  localparam int ADDR_W  = $clog2(NUM_CH);
  localparam int FRAME_W = 2 + ADDR_W + CODE_W;

  logic [FRAME_W-1:0] word;
  logic               commit;
  logic [NUM_CH-1:0]  inhibit;
  logic               act;

  qdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (sclk),
    .rst_n    (rst_n),
    .sdi      (sdi),
    .frame    (frame),
    .word_o   (word),
    .commit_o (commit)
  );

  qdac_regbank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_regs (
    .clk       (sclk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .word_i    (word[FRAME_W-2:0]),
    .codes_o   (code_o),
    .range_o   (range_o),
    .inhibit_o (inhibit),
    .act_o     (act),
    .mode_o    (mode_o)
  );

  qdac_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk       (sclk),
    .rst_n     (rst_n),
    .hw_act    (hw_act),
    .inhibit_i (inhibit),
    .act_i     (act),
    .active_o  (active_o)
  );
endmodule

// File: tb/qdac_serial_regs_test.sv
module qdac_serial_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdi = 1'b0;
  logic        frame = 1'b0;
  logic        hw_act = 1'b0;
  logic [31:0] code_o;
  logic [3:0]  range_o;
  logic        mode_o;
  logic [3:0]  active_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_code = 32'h0;
  logic [3:0]  exp_rng  = 4'hF;
  logic        exp_mode = 1'b0;

  qdac_serial_regs uut (
    .sclk(sclk), .rst_n(rst_n), .sdi(sdi), .frame(frame), .hw_act(hw_act),
    .code_o(code_o), .range_o(range_o), .mode_o(mode_o), .active_o(active_o)
  );

  always #(CLK_PERIOD/2) sclk = ~sclk;

  task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [11:0] data_word(input logic [1:0] ch, input logic [7:0] code);
    return {1'b1, 1'b1, ch, code};
  endfunction

  function automatic logic [11:0] ctrl_word(input logic md, input logic [3:0] rng,
                                            input logic [3:0] si, input logic a);
    return {1'b1, 1'b0, md, rng[0], rng[1], rng[2], rng[3], si[0], si[1], si[2], si[3], a};
  endfunction

  task automatic send(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge sclk);
      frame = 1'b1;
      sdi   = bits[i];
    end
    @(negedge sclk);
    frame = 1'b0;
    sdi   = 1'b0;
    @(negedge sclk);
  endtask

  task automatic check_regs(input string req);
    check(req, code_o, exp_code);
    check(req, {28'h0, range_o}, {28'h0, exp_rng});
    check(req, {31'h0, mode_o}, {31'h0, exp_mode});
  endtask

  task automatic t_reset;
    check("R1 codes", code_o, 32'h0);
    check("R1 range", {28'h0, range_o}, 32'hF);
    check("R1 mode", {31'h0, mode_o}, 32'h0);
    check("R1 active", {28'h0, active_o}, 32'h0);
  endtask

  task automatic t_data;
    send({4'h0, data_word(2'd0, 8'hA5)}, 12);
    exp_code[7:0] = 8'hA5;
    check_regs("R2 R3 write A");
    send({4'h0, data_word(2'd1, 8'h3C)}, 12);
    exp_code[15:8] = 8'h3C;
    send({4'h0, data_word(2'd2, 8'hFF)}, 12);
    exp_code[23:16] = 8'hFF;
    send({4'h0, data_word(2'd3, 8'h01)}, 12);
    exp_code[31:24] = 8'h01;
    check_regs("R3 write all channels");
    send({4'h0, data_word(2'd1, 8'h80)}, 12);
    exp_code[15:8] = 8'h80;
    check_regs("R3 overwrite B");
  endtask

  task automatic t_ctrl;
    send({4'h0, ctrl_word(1'b1, 4'b0101, 4'b0000, 1'b0)}, 12);
    exp_rng = 4'b0101; exp_mode = 1'b1;
    check_regs("R4 control write");
    check("R4 status off", {28'h0, active_o}, 32'h0);
    send({4'h0, ctrl_word(1'b0, 4'b1010, 4'b0000, 1'b0)}, 12);
    exp_rng = 4'b1010; exp_mode = 1'b0;
    check_regs("R4 control rewrite");
  endtask

  task automatic t_status;
    send({4'h0, ctrl_word(1'b0, exp_rng, 4'b1010, 1'b0)}, 12);
    check("R5 inhibit B D", {28'h0, active_o}, 32'hA);
    send({4'h0, ctrl_word(1'b0, exp_rng, 4'b1010, 1'b1)}, 12);
    check("R6 act without hw", {28'h0, active_o}, 32'hA);
    hw_act = 1'b1;
    repeat (3) @(negedge sclk);
    check("R6 act and hw", {28'h0, active_o}, 32'hF);
    send({4'h0, ctrl_word(1'b0, exp_rng, 4'b0000, 1'b0)}, 12);
    check("R6 hw without act", {28'h0, active_o}, 32'h0);
    send({4'h0, ctrl_word(1'b0, exp_rng, 4'b1111, 1'b0)}, 12);
    check("R5 all inhibit", {28'h0, active_o}, 32'hF);
  endtask

  task automatic t_sync;
    send({4'h0, ctrl_word(1'b0, exp_rng, 4'b0000, 1'b1)}, 12);
    hw_act = 1'b0;
    repeat (3) @(negedge sclk);
    check("R7 settled low", {28'h0, active_o}, 32'h0);
    hw_act = 1'b1;
    @(negedge sclk);
    check("R7 one edge", {28'h0, active_o}, 32'h0);
    @(negedge sclk);
    check("R7 two edges", {28'h0, active_o}, 32'hF);
    hw_act = 1'b0;
    @(negedge sclk);
    check("R7 fall one edge", {28'h0, active_o}, 32'hF);
    @(negedge sclk);
    check("R7 fall two edges", {28'h0, active_o}, 32'h0);
  endtask

  task automatic t_bad_len;
    send({5'h0, data_word(2'd0, 8'h55)}, 11);
    check_regs("R8 short frame");
    send({3'h0, data_word(2'd0, 8'h55), 1'b1}, 13);
    check_regs("R8 long frame");
    send({4'h0, ctrl_word(1'b1, 4'b0000, 4'b1111, 1'b1)}, 11);
    check_regs("R8 short control");
  endtask

  task automatic t_bad_start;
    send({4'h0, 1'b0, 1'b1, 2'd2, 8'h77}, 12);
    check_regs("R9 data start 0");
    send({4'h0, 1'b0, 1'b0, 10'b1000011111}, 12);
    check_regs("R9 control start 0");
    send({4'h0, data_word(2'd2, 8'h77)}, 12);
    exp_code[23:16] = 8'h77;
    check_regs("R2 valid after rejects");
  endtask

  initial begin
    repeat (3) @(negedge sclk);
    t_reset();
    rst_n = 1'b1;
    @(negedge sclk);
    t_reset();
    t_data();
    t_ctrl();
    t_status();
    t_sync();
    t_bad_len();
    t_bad_start();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule